// File: doc/BRIEF.md
# Link BIST Error Monitor

This block is the receive-side controller of a link self-test. A test runs for as long as either an enable pin or an enable register bit is held. The block raises a request flag toward the remote transmitter, along with a flag that picks the internal 33 MHz oscillator instead of the external pixel clock. It then checks each received word against a PRBS-7 sequence and counts the frames that contain at least one bad word.

The PASS output shows each errored frame as a low pulse lasting half a pixel clock. Once the test ends, PASS keeps the verdict of that test until a new test starts or the block is reset. A loss of lock clears the error count and makes the checker search for the sequence again. When a test ends, the block emits a one-cycle step request for the equalizer, and an equalizer reset request on the cycle after it.

Top module: `bist_err_mon`

## Requirements
- R1: The test is active while `en_pin` or `en_reg` is high. `req_bist_o` goes high at the first clock edge that sees either one high, and goes low at the first edge that sees both low.
- R2: `req_osc_o` is registered at the same edge as `req_bist_o`. It is high only when the test is requested and `osc_sel_pin` or `osc_sel_reg` is high.
- R3: The expected data is PRBS-7 with polynomial x^7+x^6+1. Each word is made of DATA_W successive generator bits, with the earliest bit placed in the MSB. The generator state after a word equals that word's low 7 bits. While hunting, each word reseeds the generator, and a frame whose words all follow one another moves the checker to tracking. Frames seen while hunting never count and never pulse PASS.
- R4: While tracking, a frame is errored if any of its words differs from the free-running expected word. For an errored frame, `pass_o` is low during the second half of the clock cycle that follows the edge capturing the frame's last word (`rx_last` high). During a test, `pass_o` is high at all other times.
- R5: `err_cnt_o` adds one per errored frame and saturates at 2^CNT_W-1. It is cleared one cycle after a test starts.
- R6: `lock` low at a clock edge clears `err_cnt_o` and returns the checker to hunting.
- R7: Once the test has ended, `pass_o` holds high if the test had no errored frame and low otherwise. It keeps that value until the next test starts. Words received while no test runs have no effect on `pass_o` or `err_cnt_o`.
- R8: `aeq_step_o` is high for exactly the one cycle that begins at the edge where `req_bist_o` falls. `aeq_rst_o` is high for the one cycle after that.
- R9: `lock_o` equals `lock` delayed by one clock, at all times.
- R10: While `rst_n` is low, `pass_o` is high and `req_bist_o`, `req_osc_o`, `aeq_step_o`, `aeq_rst_o` and `err_cnt_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-down) |
| en_pin | input | 1 | Test enable from a pin |
| en_reg | input | 1 | Test enable from a register bit |
| osc_sel_pin | input | 1 | Oscillator select from a pin |
| osc_sel_reg | input | 1 | Oscillator select from a register bit |
| lock | input | 1 | Receiver lock status |
| rx_vld | input | 1 | Received word valid |
| rx_last | input | 1 | Last word of a frame |
| rx_data | input | DATA_W | Received data word |
| req_bist_o | output | 1 | Test request to the remote transmitter |
| req_osc_o | output | 1 | Internal oscillator request forwarded with the test request |
| lock_o | output | 1 | Registered lock status |
| pass_o | output | 1 | Live error pulses, then the held verdict |
| err_cnt_o | output | CNT_W | Saturating count of errored frames |
| aeq_step_o | output | 1 | Equalizer step request at the end of a test |
| aeq_rst_o | output | 1 | Equalizer reset request, one cycle after the step |

## Verification
The request flags, `lock_o` and the start-of-test count clear each pass through a single register, so the bench checks them a quarter period after the first or second edge following the stimulus. A frame's error pulse is due in the second half of the cycle after the edge that captures its last word. The bench samples `pass_o` at 3, 7 and 13 time units after that edge to see high, then the pulse, then high again. The equalizer requests are checked on the two cycles after the end of a test, and the held verdict is checked at both half-cycle phases of several idle cycles.

// File: rtl/bist_pkg.sv
package bist_pkg;
   localparam int unsigned PRBS_LEN = 7;
   typedef enum logic {
      CHK_HUNT  = 1'b0,
      CHK_TRACK = 1'b1
   } chk_state_e;
endpackage

// File: rtl/bist_ctl.sv
module bist_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic en_pin,
   input  logic en_reg,
   input  logic sel_pin,
   input  logic sel_reg,
   output logic run_o,
   output logic start_o,
   output logic osc_o,
   output logic step_o,
   output logic eq_rst_o
);
   logic en_any;
   logic run_q, start_q, osc_q, step_q, eqr_q;

   assign en_any = en_pin | en_reg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         start_q <= 1'b0;
         osc_q   <= 1'b0;
         step_q  <= 1'b0;
         eqr_q   <= 1'b0;
      end else begin
         run_q   <= en_any;
         start_q <= en_any & ~run_q;
         osc_q   <= en_any & (sel_pin | sel_reg);
         step_q  <= run_q & ~en_any;
         eqr_q   <= step_q;
      end
   end

   assign run_o    = run_q;
   assign start_o  = start_q;
   assign osc_o    = osc_q;
   assign step_o   = step_q;
   assign eq_rst_o = eqr_q;
endmodule

// File: rtl/bist_frame_chk.sv
module bist_frame_chk #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              lock,
   input  logic              vld,
   input  logic              last,
   input  logic [DATA_W-1:0] data,
   output logic              bad_o,
   output logic              bad_tgl_o
);
   import bist_pkg::*;

   localparam int unsigned SL = PRBS_LEN;

   function automatic logic [DATA_W-1:0] prbs_word(input logic [SL-1:0] seed);
      logic [SL-1:0]     st;
      logic [DATA_W-1:0] w;
      logic              nb;
      st = seed;
      w  = '0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         nb   = st[SL-1] ^ st[SL-2];
         st   = {st[SL-2:0], nb};
         w[i] = nb;
      end
      return w;
   endfunction

   chk_state_e        st_q;
   logic [SL-1:0]     lfsr_q;
   logic              acc_q;
   logic              first_q;
   logic              bad_q;
   logic              tgl_q;
   logic [DATA_W-1:0] exp_w;
   logic              mis;
   logic              active;
   logic              hunt_mis;
   logic              frame_err;

   assign active   = run & lock;
   assign exp_w    = prbs_word(lfsr_q);
   assign mis      = (data != exp_w);
   assign hunt_mis = mis & ~first_q;

   always_comb begin
      if (st_q == CHK_TRACK) frame_err = acc_q | mis;
      else                   frame_err = acc_q | hunt_mis;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= CHK_HUNT;
         lfsr_q  <= '0;
         acc_q   <= 1'b0;
         first_q <= 1'b1;
         bad_q   <= 1'b0;
         tgl_q   <= 1'b0;
      end else begin
         bad_q <= 1'b0;
         if (!active) begin
            st_q    <= CHK_HUNT;
            acc_q   <= 1'b0;
            first_q <= 1'b1;
         end else if (vld) begin
            first_q <= 1'b0;
            if (st_q == CHK_TRACK) begin
               lfsr_q <= exp_w[SL-1:0];
               if (last) begin
                  acc_q <= 1'b0;
                  bad_q <= frame_err;
                  tgl_q <= tgl_q ^ frame_err;
               end else begin
                  acc_q <= frame_err;
               end
            end else begin
               lfsr_q <= data[SL-1:0];
               if (last) begin
                  acc_q <= 1'b0;
                  if (!frame_err) st_q <= CHK_TRACK;
               end else begin
                  acc_q <= frame_err;
               end
            end
         end
      end
   end

   assign bad_o     = bad_q;
   assign bad_tgl_o = tgl_q;
endmodule

// File: rtl/bist_err_cnt.sv
module bist_err_cnt #(
   parameter int unsigned CNT_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;

   generate
      if (SATURATE) begin : g_sat
         always_comb cnt_nx = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      end else begin : g_wrap
         always_comb cnt_nx = cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_nx;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/bist_pass_out.sv
module bist_pass_out (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic start,
   input  logic bad,
   input  logic bad_tgl,
   output logic pass_o
);
   logic fail_q;
   logic dly_q;
   logic neg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_q <= 1'b0;
         dly_q  <= 1'b0;
      end else begin
         dly_q <= bad_tgl;
         if (start)    fail_q <= 1'b0;
         else if (bad) fail_q <= 1'b1;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) neg_q <= 1'b0;
      else        neg_q <= bad_tgl;
   end

   assign pass_o = (run | ~fail_q) & ~(neg_q ^ dly_q);
endmodule

// File: rtl/bist_err_mon.sv
module bist_err_mon #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CNT_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_pin,
   input  logic              en_reg,
   input  logic              osc_sel_pin,
   input  logic              osc_sel_reg,
   input  logic              lock,
   input  logic              rx_vld,
   input  logic              rx_last,
   input  logic [DATA_W-1:0] rx_data,
   output logic              req_bist_o,
   output logic              req_osc_o,
   output logic              lock_o,
   output logic              pass_o,
   output logic [CNT_W-1:0]  err_cnt_o,
   output logic              aeq_step_o,
   output logic              aeq_rst_o
);
   import bist_pkg::*;

   generate
      if (DATA_W < PRBS_LEN) begin : g_bad_dw
         $error("bist_err_mon: DATA_W must be at least the PRBS order");
      end
      if (CNT_W < 1) begin : g_bad_cw
         $error("bist_err_mon: CNT_W must be at least 1");
      end
   endgenerate

   logic run, start, bad, bad_tgl, lock_q;

   bist_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_pin   (en_pin),
      .en_reg   (en_reg),
      .sel_pin  (osc_sel_pin),
      .sel_reg  (osc_sel_reg),
      .run_o    (run),
      .start_o  (start),
      .osc_o    (req_osc_o),
      .step_o   (aeq_step_o),
      .eq_rst_o (aeq_rst_o)
   );

   bist_frame_chk #(.DATA_W(DATA_W)) u_chk (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .lock      (lock),
      .vld       (rx_vld),
      .last      (rx_last),
      .data      (rx_data),
      .bad_o     (bad),
      .bad_tgl_o (bad_tgl)
   );

   bist_err_cnt #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start | ~lock),
      .inc   (bad),
      .cnt_o (err_cnt_o)
   );

   bist_pass_out u_pass (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .start   (start),
      .bad     (bad),
      .bad_tgl (bad_tgl),
      .pass_o  (pass_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q <= 1'b0;
      else        lock_q <= lock;
   end

   assign req_bist_o = run;
   assign lock_o     = lock_q;
endmodule

// File: rtl/bist_err_mon_chk.sv
module bist_err_mon_chk #(
   parameter int unsigned CNT_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_pin,
   input logic             en_reg,
   input logic             lock,
   input logic             req_bist_o,
   input logic             req_osc_o,
   input logic             lock_o,
   input logic             pass_o,
   input logic [CNT_W-1:0] err_cnt_o,
   input logic             aeq_step_o,
   input logic             aeq_rst_o
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   AST_REQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (en_pin | en_reg) |=> req_bist_o); // R1
   AST_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_pin | en_reg) |=> !req_bist_o); // R1
   AST_OSC_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_osc_o |-> req_bist_o); // R2
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt_o != $past(err_cnt_o)) |-> (err_cnt_o == $past(err_cnt_o) + 1'b1 || err_cnt_o == '0)); // R5
   AST_LOCK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !lock |=> (err_cnt_o == '0)); // R6
   AST_PASS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_bist_o && !$past(req_bist_o) && !$past(req_bist_o, 2) && !$past(req_bist_o, 3)) |-> $stable(pass_o)); // R7
   AST_STEP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_bist_o) |-> aeq_step_o); // R8
   AST_RST_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      aeq_step_o |=> (aeq_rst_o && !aeq_step_o)); // R8
   AST_LOCK_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock_o); // R9

   generate
      if (SATURATE) begin : g_sat_chk
         AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (err_cnt_o == CMAX) |=> (err_cnt_o == CMAX || err_cnt_o == '0)); // R5
      end
   endgenerate
endmodule

bind bist_err_mon bist_err_mon_chk #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_bind_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en_pin     (en_pin),
   .en_reg     (en_reg),
   .lock       (lock),
   .req_bist_o (req_bist_o),
   .req_osc_o  (req_osc_o),
   .lock_o     (lock_o),
   .pass_o     (pass_o),
   .err_cnt_o  (err_cnt_o),
   .aeq_step_o (aeq_step_o),
   .aeq_rst_o  (aeq_rst_o)
);

// File: tb/sim_bist_err_mon.sv
module sim_bist_err_mon;
   localparam int CLK_P = 10;
   localparam int DW    = 8;
   localparam int CW    = 4;
   localparam int CMAX  = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en_pin = 1'b0, en_reg = 1'b0;
   logic          osc_sel_pin = 1'b0, osc_sel_reg = 1'b0;
   logic          lock = 1'b1;
   logic          rx_vld = 1'b0, rx_last = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          req_bist_o, req_osc_o, lock_o, pass_o, aeq_step_o, aeq_rst_o;
   logic [CW-1:0] err_cnt_o;

   int total = 0;
   int bad = 0;
   int exp_cnt = 0;
   logic [6:0] b_lfsr = 7'h7F;

   bist_err_mon #(.DATA_W(DW), .CNT_W(CW), .SATURATE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en_reg(en_reg),
      .osc_sel_pin(osc_sel_pin), .osc_sel_reg(osc_sel_reg), .lock(lock),
      .rx_vld(rx_vld), .rx_last(rx_last), .rx_data(rx_data),
      .req_bist_o(req_bist_o), .req_osc_o(req_osc_o), .lock_o(lock_o),
      .pass_o(pass_o), .err_cnt_o(err_cnt_o), .aeq_step_o(aeq_step_o),
      .aeq_rst_o(aeq_rst_o)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic gen_word(output logic [DW-1:0] w);
      logic nb;
      for (int i = DW - 1; i >= 0; i--) begin
         nb     = b_lfsr[6] ^ b_lfsr[5];
         b_lfsr = {b_lfsr[5:0], nb};
         w[i]   = nb;
      end
   endtask

   // send nw words; corrupt word bad_idx (-1 none); check pass_o at 3/7/13 after capture edge
   task automatic send_frame(input int nw, input int bad_idx, input bit base,
                             input bit mid, input string req);
      logic [DW-1:0] w;
      for (int i = 0; i < nw; i++) begin
         gen_word(w);
         if (i == bad_idx) w = w ^ 8'h10;
         step();
         rx_vld  = 1'b1;
         rx_data = w;
         rx_last = (i == nw - 1);
      end
      @(posedge clk);
      #1;
      rx_vld  = 1'b0;
      rx_last = 1'b0;
      #2;
      chk(pass_o == base, {req, " pass first half"}, pass_o, base);
      #4;
      chk(pass_o == mid, {req, " pass second half"}, pass_o, mid);
      #6;
      chk(pass_o == base, {req, " pass next cycle"}, pass_o, base);
   endtask

   task automatic chk_cnt(input string req);
      step();
      step();
      chk(err_cnt_o == exp_cnt[CW-1:0], req, err_cnt_o, exp_cnt);
   endtask

   initial begin
      #(CLK_P * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R10 reset values
      repeat (3) @(posedge clk);
      #3;
      chk(pass_o == 1'b1, "R10 pass", pass_o, 1);
      chk(req_bist_o == 1'b0 && req_osc_o == 1'b0, "R10 req", {req_bist_o, req_osc_o}, 0);
      chk(aeq_step_o == 1'b0 && aeq_rst_o == 1'b0, "R10 aeq", {aeq_step_o, aeq_rst_o}, 0);
      chk(err_cnt_o == '0, "R10 cnt", err_cnt_o, 0);
      step();
      rst_n = 1'b1;
      step();

      // R1 R2 R9 sweep of all enable/select combinations
      for (int e = 0; e < 16; e++) begin
         en_pin      = e[0];
         en_reg      = e[1];
         osc_sel_pin = e[2];
         osc_sel_reg = e[3];
         lock        = e[1] ^ e[2];
         @(posedge clk);
         #3;
         chk(req_bist_o == (e[0] | e[1]), "R1 req sweep", req_bist_o, e[0] | e[1]);
         chk(req_osc_o == ((e[0] | e[1]) & (e[2] | e[3])), "R2 osc sweep", req_osc_o,
             (e[0] | e[1]) & (e[2] | e[3]));
         chk(lock_o == (e[1] ^ e[2]), "R9 lock delay", lock_o, e[1] ^ e[2]);
      end
      en_pin = 0; en_reg = 0; osc_sel_pin = 0; osc_sel_reg = 0; lock = 1;
      repeat (3) step();

      // Test via pin
      en_pin = 1'b1;
      step();
      step();
      exp_cnt = 0;
      send_frame(4, 2, 1'b1, 1'b1, "R3 hunt error ignored");
      chk_cnt("R3 hunt count");
      send_frame(4, -1, 1'b1, 1'b1, "R3 sync frame");
      send_frame(3, 0, 1'b1, 1'b0, "R4 error first word");
      exp_cnt++; chk_cnt("R5 count 1");
      send_frame(5, 4, 1'b1, 1'b0, "R4 error last word");
      exp_cnt++; chk_cnt("R5 count 2");
      send_frame(1, 0, 1'b1, 1'b0, "R4 single word frame");
      exp_cnt++; chk_cnt("R5 count 3");
      send_frame(6, -1, 1'b1, 1'b1, "R4 clean frame");
      chk_cnt("R4 clean no count");

      // R6 loss of lock
      lock = 1'b0;
      step();
      lock = 1'b1;
      exp_cnt = 0;
      chk_cnt("R6 lock clears count");
      send_frame(4, 1, 1'b1, 1'b1, "R6 back to hunt");
      chk_cnt("R6 hunt no count");
      send_frame(4, -1, 1'b1, 1'b1, "R6 resync");
      send_frame(2, 1, 1'b1, 1'b0, "R6 error after resync");
      exp_cnt++; chk_cnt("R6 count after resync");

      // R5 saturation
      for (int k = 0; k < CMAX + 2; k++) begin
         send_frame(2, k % 2, 1'b1, 1'b0, "R5 sat frame");
         if (exp_cnt < CMAX) exp_cnt++;
      end
      chk_cnt("R5 saturated");

      // R8 end of test
      en_pin = 1'b0;
      @(posedge clk);
      #3;
      chk(req_bist_o == 1'b0, "R1 req drop", req_bist_o, 0);
      chk(aeq_step_o == 1'b1 && aeq_rst_o == 1'b0, "R8 step cycle", {aeq_step_o, aeq_rst_o}, 2);
      @(posedge clk);
      #3;
      chk(aeq_step_o == 1'b0 && aeq_rst_o == 1'b1, "R8 reset cycle", {aeq_step_o, aeq_rst_o}, 1);
      @(posedge clk);
      #3;
      chk(aeq_step_o == 1'b0 && aeq_rst_o == 1'b0, "R8 quiet", {aeq_step_o, aeq_rst_o}, 0);

      // R7 held fail verdict, idle frames ignored
      for (int k = 0; k < 4; k++) begin
         @(posedge clk);
         #3;
         chk(pass_o == 1'b0, "R7 fail held early", pass_o, 0);
         #4;
         chk(pass_o == 1'b0, "R7 fail held late", pass_o, 0);
      end
      send_frame(3, 1, 1'b0, 1'b0, "R7 idle frame ignored");
      chk_cnt("R7 idle count unchanged");

      // Test via register: verdict and count cleared at start
      en_reg = 1'b1;
      @(posedge clk);
      #3;
      chk(pass_o == 1'b1, "R7 new test releases pass", pass_o, 1);
      exp_cnt = 0;
      chk_cnt("R5 cleared at start");
      send_frame(3, -1, 1'b1, 1'b1, "R3 sync via reg");
      send_frame(4, -1, 1'b1, 1'b1, "R4 clean tracking");
      send_frame(2, -1, 1'b1, 1'b1, "R4 clean tracking 2");
      en_reg = 1'b0;
      repeat (4) step();
      for (int k = 0; k < 3; k++) begin
         @(posedge clk);
         #3;
         chk(pass_o == 1'b1, "R7 pass held early", pass_o, 1);
         #4;
         chk(pass_o == 1'b1, "R7 pass held late", pass_o, 1);
      end
      chk_cnt("R5 clean test count");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule